// File: doc/BRIEF.md
# Interrupt Status, Enable and Mask Unit

This unit gathers single-cycle event pulses from the parts of a network controller into a status register whose bits clear when software reads it. Each source has an enable bit. The block drives one interrupt line that is high while any captured event belongs to an enabled source. Software changes the enables through two write-one registers. One sets enable bits and the other clears them, so no read-modify-write is needed. A read-only mask register reports which sources are currently masked.

There are fourteen bit positions. Bit 8 is a reserved hole. The thirteen live sources, by bit, are:

| Bit | Source |
|-----|--------|
| 0 | management transfer done |
| 1 | receive complete |
| 2 | receive descriptor used-bit read |
| 3 | transmit descriptor used-bit read |
| 4 | transmit underrun |
| 5 | retry limit |
| 6 | transmit buffers exhausted |
| 7 | transmit complete |
| 9 | link change |
| 10 | receive overrun |
| 11 | bus error response |
| 12 | pause frame received |
| 13 | pause time reached zero |

Registers sit on a small register bus with a 2-bit word select. Read data is registered and appears on the cycle after the read strobe.

Top module: `irq_status_unit`

## Requirements
- R1: An event pulse on a live source sets its status bit (bit n of status, select 0) at the next clock edge. The bit stays set until status is read.
- R2: A read of the status register (select 0) returns the status and clears every status bit at the same edge.
- R3: An event that arrives in the same cycle as a status read is not lost. It does not appear in that read's data, and it is set in status afterwards.
- R4: Writing 1 to a bit of the enable-set register (select 1) enables that source. A 0 bit leaves that source unchanged.
- R5: Writing 1 to a bit of the enable-clear register (select 2) disables that source. A 0 bit leaves that source unchanged.
- R6: A read of the mask register (select 3) returns a 1 for every live source that is disabled.
- R7: Bit 8 reads as 0 in status and in mask. An event on bit 8 is ignored, and bit 8 cannot be enabled.
- R8: The interrupt line is high exactly when some status bit is set and its source is enabled.
- R9: After reset, all status bits are 0, every live source is masked (mask reads 0x3EFF), read data is 0 and the interrupt line is low.
- R10: Writes to select 0 or select 3 have no effect. Reads of select 1 or select 2 return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| evt_i | input | 14 | per-source event pulses, bit 8 reserved |
| bus_rd_i | input | 1 | read strobe |
| bus_wr_i | input | 1 | write strobe |
| bus_addr_i | input | 2 | register select |
| bus_wdata_i | input | 32 | write data |
| bus_rdata_o | output | 32 | registered read data, valid the cycle after the strobe |
| irq_o | output | 1 | interrupt line |

## Verification
The event patterns used are a single pulse, all fourteen bits at once including the reserved bit, and a pulse that lands in the same cycle as a status read. Together they separate correct capture from a lost event and from a leak through bit 8. The enable patterns are a full set, a partial clear and all-zero writes. These show write-one semantics apart from plain overwrite. The interrupt line is compared on every cycle against a model. This catches masked sources that still raise it, and enabled sources that stay silent after a clearing read.

// File: rtl/isu_pkg.sv
package isu_pkg;
  typedef enum logic [1:0] {
    SEL_STATUS = 2'd0,
    SEL_ENSET  = 2'd1,
    SEL_ENCLR  = 2'd2,
    SEL_MASK   = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/isu_capture.sv
module isu_capture #(
  parameter int          N_SRC = 14,
  parameter logic [13:0] LIVE  = 14'h3EFF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] evt_i,
  input  logic             clr_i,
  output logic [N_SRC-1:0] status_o
);
  logic [N_SRC-1:0] status_q, status_d, evt_live;

  assign evt_live = evt_i & LIVE[N_SRC-1:0];

  always_comb begin
    status_d = clr_i ? '0 : status_q;
    status_d = status_d | evt_live;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= status_d;
  end

  assign status_o = status_q;

  assert_evt_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_live) |=> ((status_q & $past(evt_live)) == $past(evt_live)));
  assert_read_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && evt_i == '0) |=> (status_q == '0));
  assert_rsvd_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q & ~LIVE[N_SRC-1:0]) == '0);
endmodule

// File: rtl/isu_enable.sv
module isu_enable #(
  parameter int          N_SRC = 14,
  parameter logic [13:0] LIVE  = 14'h3EFF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_we_i,
  input  logic             clr_we_i,
  input  logic [N_SRC-1:0] bits_i,
  output logic [N_SRC-1:0] en_o
);
  logic [N_SRC-1:0] en_q, en_d, set_v, clr_v;
  logic             en_ce;

  assign set_v = set_we_i ? (bits_i & LIVE[N_SRC-1:0]) : '0;
  assign clr_v = clr_we_i ? bits_i : '0;
  assign en_ce = set_we_i | clr_we_i;

  always_comb begin
    en_d = (en_q & ~clr_v) | set_v;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (en_ce) en_q <= en_d;
  end

  assign en_o = en_q;

  assert_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    set_we_i |=> ((en_q & $past(set_v)) == $past(set_v)));
  assert_clr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we_i && !set_we_i) |=> ((en_q & $past(clr_v)) == '0));
  assert_rsvd_en_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q & ~LIVE[N_SRC-1:0]) == '0);
endmodule

// File: rtl/isu_regbus.sv
module isu_regbus
  import isu_pkg::*;
#(
  parameter int          N_SRC  = 14,
  parameter int          DATA_W = 32,
  parameter logic [13:0] LIVE   = 14'h3EFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [1:0]        addr_i,
  input  logic [N_SRC-1:0]  status_i,
  input  logic [N_SRC-1:0]  en_i,
  output logic              status_clr_o,
  output logic              en_set_o,
  output logic              en_clr_o,
  output logic [DATA_W-1:0] rdata_o
);
  reg_sel_e          sel;
  logic [N_SRC-1:0]  rd_mux;
  logic [DATA_W-1:0] rdata_q, rdata_d;

  assign sel          = reg_sel_e'(addr_i);
  assign status_clr_o = rd_i && sel == SEL_STATUS;
  assign en_set_o     = wr_i && sel == SEL_ENSET;
  assign en_clr_o     = wr_i && sel == SEL_ENCLR;

  always_comb begin
    unique case (sel)
      SEL_STATUS: rd_mux = status_i;
      SEL_MASK:   rd_mux = ~en_i & LIVE[N_SRC-1:0];
      default:    rd_mux = '0;
    endcase
    rdata_d = {{(DATA_W-N_SRC){1'b0}}, rd_mux};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    rdata_q <= '0;
    else if (rd_i) rdata_q <= rdata_d;
  end

  assign rdata_o = rdata_q;

  assert_wo_reads_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && (addr_i == 2'd1 || addr_i == 2'd2)) |=> (rdata_q == '0));
  assert_rsvd_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_q[8] == 1'b0);
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit #(
  parameter int          N_SRC  = 14,
  parameter int          DATA_W = 32,
  parameter logic [13:0] LIVE   = 14'h3EFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  evt_i,
  input  logic              bus_rd_i,
  input  logic              bus_wr_i,
  input  logic [1:0]        bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              irq_o
);
  logic [N_SRC-1:0] status, en;
  logic             st_clr, en_set, en_clr;

  isu_regbus #(.N_SRC(N_SRC), .DATA_W(DATA_W), .LIVE(LIVE)) u_bus (
    .clk(clk), .rst_n(rst_n), .rd_i(bus_rd_i), .wr_i(bus_wr_i),
    .addr_i(bus_addr_i), .status_i(status), .en_i(en),
    .status_clr_o(st_clr), .en_set_o(en_set), .en_clr_o(en_clr),
    .rdata_o(bus_rdata_o)
  );

  isu_capture #(.N_SRC(N_SRC), .LIVE(LIVE)) u_cap (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .clr_i(st_clr),
    .status_o(status)
  );

  isu_enable #(.N_SRC(N_SRC), .LIVE(LIVE)) u_en (
    .clk(clk), .rst_n(rst_n), .set_we_i(en_set), .clr_we_i(en_clr),
    .bits_i(bus_wdata_i[N_SRC-1:0]), .en_o(en)
  );

  assign irq_o = |(status & en);

  assert_irq_needs_en_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (en != '0 && status != '0));
  assert_read_drops_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_clr && evt_i == '0 && !en_set) |=> !irq_o);
endmodule

// File: tb/irq_status_unit_test.sv
module irq_status_unit_test;
  localparam logic [13:0] LIVE = 14'h3EFF;

  typedef struct {
    bit          is_rd;
    logic [31:0] rd;
    logic        irq;
    string       tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [13:0] evt;
  logic        rd, wr;
  logic [1:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        irq;

  item_t       sb[$];
  logic [13:0] m_status, m_en;
  int          n_chk = 0, n_fail = 0;
  bit          done = 0;

  always #4 clk = ~clk;

  irq_status_unit uut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .bus_rd_i(rd), .bus_wr_i(wr),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: one bus/event cycle, pushes expected result into scoreboard
  task automatic cyc(string tag, logic [13:0] e, bit r, bit w,
                     logic [1:0] a, logic [31:0] d);
    item_t it;
    @(negedge clk);
    evt = e; rd = r; wr = w; addr = a; wdata = d;
    it.is_rd = r;
    it.tag   = tag;
    it.rd    = 32'h0;
    if (r) begin
      if (a == 2'd0) it.rd = {18'h0, m_status};
      else if (a == 2'd3) it.rd = {18'h0, ~m_en & LIVE};
    end
    if (r && a == 2'd0) m_status = '0;
    m_status = m_status | (e & LIVE);
    if (w && a == 2'd1) m_en = m_en | (d[13:0] & LIVE);
    if (w && a == 2'd2) m_en = m_en & ~d[13:0];
    it.irq = |(m_status & m_en);
    @(posedge clk);
    sb.push_back(it);
    #1;
    evt = '0; rd = 0; wr = 0;
  endtask

  // monitor
  always @(negedge clk) begin
    while (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      if (it.is_rd) check({it.tag, " rdata"}, rdata, it.rd);
      check({it.tag, " R8 irq"}, {31'h0, irq}, {31'h0, it.irq});
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 0; evt = '0; rd = 0; wr = 0; addr = '0; wdata = '0;
    m_status = '0; m_en = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R9 reset rdata", rdata, 32'h0);
    check("R9 reset irq", {31'h0, irq}, 32'h0);
    @(negedge clk) rst_n = 1;
    cyc("R9 mask after reset", '0, 1, 0, 2'd3, '0);
    cyc("R9 status after reset", '0, 1, 0, 2'd0, '0);
    // R1 single pulse, R2 clear on read
    cyc("R1 pulse", 14'h0001, 0, 0, 2'd0, '0);
    cyc("R1 idle", '0, 0, 0, 2'd0, '0);
    cyc("R1 read", '0, 1, 0, 2'd0, '0);
    cyc("R2 reread", '0, 1, 0, 2'd0, '0);
    // R7 all bits including reserved
    cyc("R7 all events", 14'h3FFF, 0, 0, 2'd0, '0);
    cyc("R7 R1 read all", '0, 1, 0, 2'd0, '0);
    // R4 enable all, R7 bit 8 cannot enable
    cyc("R4 set all", '0, 0, 1, 2'd1, 32'hFFFF_FFFF);
    cyc("R4 R7 mask", '0, 1, 0, 2'd3, '0);
    // R5 partial clear, zero writes no effect
    cyc("R5 clear low", '0, 0, 1, 2'd2, 32'h0000_000F);
    cyc("R5 zero clear", '0, 0, 1, 2'd2, 32'h0);
    cyc("R4 zero set", '0, 0, 1, 2'd1, 32'h0);
    cyc("R6 mask partial", '0, 1, 0, 2'd3, '0);
    // R8 masked vs enabled sources
    cyc("R8 masked evt", 14'h0001, 0, 0, 2'd0, '0);
    cyc("R8 masked idle", '0, 0, 0, 2'd0, '0);
    cyc("R8 enabled evt", 14'h0020, 0, 0, 2'd0, '0);
    cyc("R8 read clears", '0, 1, 0, 2'd0, '0);
    cyc("R8 after read", '0, 0, 0, 2'd0, '0);
    // R3 event coincident with read
    cyc("R3 pre", 14'h0002, 0, 0, 2'd0, '0);
    cyc("R3 read with evt", 14'h0004, 1, 0, 2'd0, '0);
    cyc("R3 survivor", '0, 1, 0, 2'd0, '0);
    // R7 reserved event alone, with bit8 enable attempt
    cyc("R7 set bit8", '0, 0, 1, 2'd1, 32'h0000_0100);
    cyc("R7 evt bit8", 14'h0100, 0, 0, 2'd0, '0);
    cyc("R7 status bit8", '0, 1, 0, 2'd0, '0);
    // R10 writes to read-only, reads of write-only
    cyc("R10 pre evt", 14'h0400, 0, 0, 2'd0, '0);
    cyc("R10 write status", '0, 0, 1, 2'd0, 32'hFFFF_FFFF);
    cyc("R10 write mask", '0, 0, 1, 2'd3, 32'hFFFF_FFFF);
    cyc("R10 read set reg", '0, 1, 0, 2'd1, '0);
    cyc("R10 read clr reg", '0, 1, 0, 2'd2, '0);
    cyc("R10 mask kept", '0, 1, 0, 2'd3, '0);
    cyc("R10 status kept", '0, 1, 0, 2'd0, '0);
    // R5 disable everything
    cyc("R5 clear all", 14'h2000, 0, 1, 2'd2, 32'hFFFF_FFFF);
    cyc("R5 R6 mask all", '0, 1, 0, 2'd3, '0);
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule